// File: doc/BRIEF.md
# Two-Bank Striped SRAM FIFO Controller

This controller turns two external single-port synchronous SRAM banks into one circular FIFO. Each bank holds 2^BANK_AW words of WORD_W bits. Words arriving from an upstream queue are placed in groups of four. Each group goes to the bank opposite the one the previous group used. Because of this, the oldest unread word and the newest incoming word usually sit in different banks. A memory write and a memory read can then be issued in the same cycle, one to each bank.

On the read side, one memory access yields a full word. That word is presented to a bus interface as two half-width dwords, the low half first. This lets a memory that is slower than the bus keep the bus busy for two transfers per access. The controller tracks occupancy in whole words. It raises full and empty flags from that count. A write offered while the FIFO is full is dropped, and a sticky overflow flag is set.

The SRAM command outputs are registered. A bank's read data is expected one clock after its command is seen. The controller captures it one clock after that.

Top module: `pp_sram_fifo`

## Requirements
- R1: While rst is high and on the first cycle after it: empty=1, full=0, overflow=0, dw_valid=0, and no SRAM enable is asserted.
- R2: The k-th accepted word (k counted from 0 since reset) is written to bank ((k>>2)&1), at address (((k mod 2^(BANK_AW+1))>>3)<<2)|(k&3), with its data unchanged. The write command appears on the SRAM ports one cycle after the word is sampled.
- R3: Every word leaves dw_data as two dwords: bits [31:0] first, then bits [63:32]. Words leave in acceptance order, so the number of dwords delivered is always even.
- R4: full is 1 exactly when 2^(BANK_AW+1) words are stored. empty is 1 when no word is stored. The two are never both 1.
- R5: wr_valid while full drops the word and sets overflow. Overflow stays at 1 until reset.
- R6: When the next read and an accepted write target the same bank, the write is issued and the read waits. At most one read and one write command are issued per cycle, and always to different banks. With writes back to back from an empty FIFO, the first read is issued together with the fifth write.
- R7: While dw_valid=1 and dw_ready=0, dw_valid stays 1 and dw_data holds its value.
- R8: Pointers wrap: after more than 2^(BANK_AW+1) words have passed, addressing and data order continue without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Incoming word present this cycle |
| wr_data | input | WORD_W | Incoming word |
| dw_ready | input | 1 | Bus side takes the current dword |
| dw_valid | output | 1 | dw_data holds a dword |
| dw_data | output | WORD_W/2 | Outgoing dword |
| full | output | 1 | Storage holds its maximum word count |
| empty | output | 1 | No word stored in SRAM |
| overflow | output | 1 | Sticky: a word was dropped while full |
| sram_en | output | 2 | Per-bank access enable |
| sram_we | output | 2 | Per-bank write select (1 = write) |
| sram_addr | output | 2*BANK_AW | Per-bank address, bank b at [b*BANK_AW +: BANK_AW] |
| sram_wdata | output | 2*WORD_W | Per-bank write data |
| sram_rdata | input | 2*WORD_W | Per-bank read data, valid one cycle after a read command |

## Verification
The checker watches the invariants on every clock. These are: at most one read and one write command per cycle, no write issued while full, the overflow flag being set and sticky, full and empty being exclusive, and the output holding steady under back-pressure. The bench scenarios cover what the checker cannot see. It checks the exact bank and address of every write as the stream wraps twice round a small configuration. It checks the cycle in which the stalled first read is finally released. It checks the exact point at which the FIFO fills and the next word is dropped. It also checks that the dword stream matches the accepted words split low half first.

// File: rtl/pp_fifo_pkg.sv
package pp_fifo_pkg;
  localparam int unsigned NUM_BANKS = 2;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/ppf_addr_map.sv
// Maps a circular word pointer to a bank and an in-bank address.
// Groups of 2^GRP_LG words alternate between the two banks.
module ppf_addr_map #(
  parameter int unsigned AW     = 17,
  parameter int unsigned GRP_LG = 2
) (
  input  logic [AW:0]   ptr,
  output logic          bank,
  output logic [AW-1:0] addr
);
  assign bank = ptr[GRP_LG];
  assign addr = {ptr[AW:GRP_LG+1], ptr[GRP_LG-1:0]};
endmodule

// File: rtl/ppf_occupancy.sv
// Word occupancy counter driving the full and empty flags.
module ppf_occupancy #(
  parameter int unsigned AW = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic full,
  output logic empty
);
  localparam int unsigned CW = AW + 2;
  localparam logic [CW-1:0] TOTAL = CW'(1) << (AW + 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full  = (count == TOTAL);
  assign empty = (count == '0);
endmodule

// File: rtl/ppf_splitter.sv
// Holds one word and presents it as two dwords, low half first.
module ppf_splitter
  import pp_fifo_pkg::*;
#(
  parameter int unsigned WW = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [WW-1:0]   load_word,
  input  logic            ready,
  output logic            out_valid,
  output logic [WW/2-1:0] out_data,
  output logic            done
);
  localparam int unsigned HW = WW / 2;

  half_e          half;
  logic [HW-1:0]  hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      half      <= HALF_LO;
      out_data  <= '0;
      hi_q      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      half      <= HALF_LO;
      out_data  <= load_word[HW-1:0];
      hi_q      <= load_word[WW-1:HW];
    end else if (out_valid && ready) begin
      if (half == HALF_LO) begin
        out_data <= hi_q;
        half     <= HALF_HI;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  assign done = out_valid && ready && (half == HALF_HI);
endmodule

// File: rtl/pp_sram_fifo.sv
// Two-bank striped SRAM FIFO controller.
module pp_sram_fifo
  import pp_fifo_pkg::*;
#(
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned BANK_AW = 17,
  parameter int unsigned GRP_LG  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_valid,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic                          dw_ready,
  output logic                          dw_valid,
  output logic [WORD_W/2-1:0]           dw_data,
  output logic                          full,
  output logic                          empty,
  output logic                          overflow,
  output logic [NUM_BANKS-1:0]          sram_en,
  output logic [NUM_BANKS-1:0]          sram_we,
  output logic [NUM_BANKS*BANK_AW-1:0]  sram_addr,
  output logic [NUM_BANKS*WORD_W-1:0]   sram_wdata,
  input  logic [NUM_BANKS*WORD_W-1:0]   sram_rdata
);
  localparam int unsigned PW = BANK_AW + 1;

  logic [PW-1:0]      wr_ptr, rd_ptr;
  logic               wr_bank, rd_bank;
  logic [BANK_AW-1:0] wr_addr, rd_addr;
  logic               wr_go, rd_go, busy, split_done;
  logic               rd_s1, rd_s2, rd_b1, rd_b2;
  logic [WORD_W-1:0]  cap_word;

  ppf_addr_map #(.AW(BANK_AW), .GRP_LG(GRP_LG)) u_wmap (
    .ptr(wr_ptr), .bank(wr_bank), .addr(wr_addr)
  );
  ppf_addr_map #(.AW(BANK_AW), .GRP_LG(GRP_LG)) u_rmap (
    .ptr(rd_ptr), .bank(rd_bank), .addr(rd_addr)
  );

  ppf_occupancy #(.AW(BANK_AW)) u_occ (
    .clk(clk), .rst(rst), .inc(wr_go), .dec(rd_go), .full(full), .empty(empty)
  );

  // Write wins a bank clash; the read retries next cycle.
  assign wr_go = wr_valid && !full;
  assign rd_go = !empty && !busy && !(wr_go && (wr_bank == rd_bank));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      busy     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (wr_go) wr_ptr <= wr_ptr + 1'b1;
      if (rd_go) rd_ptr <= rd_ptr + 1'b1;
      if (rd_go)           busy <= 1'b1;
      else if (split_done) busy <= 1'b0;
      if (wr_valid && full) overflow <= 1'b1;
    end
  end

  // Registered SRAM command, one port per bank.
  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rst) begin
        sram_en[b] <= 1'b0;
        sram_we[b] <= 1'b0;
      end else begin
        sram_en[b] <= (wr_go && (wr_bank == b[0])) || (rd_go && (rd_bank == b[0]));
        sram_we[b] <= wr_go && (wr_bank == b[0]);
      end
      sram_addr[b*BANK_AW +: BANK_AW] <= (wr_go && (wr_bank == b[0])) ? wr_addr : rd_addr;
      sram_wdata[b*WORD_W +: WORD_W]  <= wr_data;
    end
  end

  // Read return pipeline: command registered, SRAM answers, data captured.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_s1 <= 1'b0;
      rd_s2 <= 1'b0;
      rd_b1 <= 1'b0;
      rd_b2 <= 1'b0;
    end else begin
      rd_s1 <= rd_go;
      rd_b1 <= rd_bank;
      rd_s2 <= rd_s1;
      rd_b2 <= rd_b1;
    end
  end

  assign cap_word = rd_b2 ? sram_rdata[WORD_W +: WORD_W] : sram_rdata[0 +: WORD_W];

  ppf_splitter #(.WW(WORD_W)) u_split (
    .clk(clk), .rst(rst), .load(rd_s2), .load_word(cap_word), .ready(dw_ready),
    .out_valid(dw_valid), .out_data(dw_data), .done(split_done)
  );
endmodule

// File: rtl/ppf_checker.sv
module ppf_checker #(
  parameter int unsigned HW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic          full,
  input logic          empty,
  input logic          overflow,
  input logic          dw_valid,
  input logic          dw_ready,
  input logic [HW-1:0] dw_data,
  input logic [1:0]    sram_en,
  input logic [1:0]    sram_we
);
  // R6
  one_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sram_we));
  // R6
  one_read_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sram_en & ~sram_we));
  // R4
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  // R5
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && full) |=> (sram_we == 2'b00));
  // R5
  overflow_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && full) |=> overflow);
  // R5
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dw_valid && !dw_ready) |=> (dw_valid && $stable(dw_data)));
  // R2
  write_from_input_chk: assert property (@(posedge clk) disable iff (rst)
    (|sram_we) |-> $past(wr_valid));
endmodule

bind pp_sram_fifo ppf_checker #(.HW(WORD_W/2)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .full(full), .empty(empty),
  .overflow(overflow), .dw_valid(dw_valid), .dw_ready(dw_ready),
  .dw_data(dw_data), .sram_en(sram_en), .sram_we(sram_we)
);

// File: tb/sim_pp_sram_fifo.sv
`timescale 1ns/1ps
module sim_pp_sram_fifo;
  localparam int W   = 64;
  localparam int AW  = 3;
  localparam int TOT = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_valid = 1'b0;
  logic [W-1:0]    wr_data = '0;
  logic            dw_ready = 1'b0;
  logic            dw_valid, full, empty, overflow;
  logic [W/2-1:0]  dw_data;
  logic [1:0]      sram_en, sram_we;
  logic [2*AW-1:0] sram_addr;
  logic [2*W-1:0]  sram_wdata;
  logic [2*W-1:0]  rdata_r = '0;

  int checks = 0;
  int errors = 0;
  int wcount = 0;
  int rdc = 0;
  bit first_rd_seen = 0;
  bit full_seen_p2 = 0;
  bit phase2 = 0;
  logic [W-1:0] acc [$];
  logic [W-1:0] mem [0:1][0:7];

  always #2.5 clk = ~clk;

  pp_sram_fifo #(.WORD_W(W), .BANK_AW(AW), .GRP_LG(2)) u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .dw_ready(dw_ready), .dw_valid(dw_valid), .dw_data(dw_data),
    .full(full), .empty(empty), .overflow(overflow),
    .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_rdata(rdata_r)
  );

  // Behavioural synchronous SRAM banks
  always_ff @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (sram_en[b]) begin
        if (sram_we[b]) mem[b][sram_addr[b*AW +: AW]] <= sram_wdata[b*W +: W];
        else            rdata_r[b*W +: W] <= mem[b][sram_addr[b*AW +: AW]];
      end
    end
  end

  function automatic logic [W-1:0] word_val(int k);
    return {32'hC0DE0000 + 32'(k), 32'h00BE0000 + 32'(k)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Monitor at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (sram_we != 2'b00) begin
        int wb;
        int k;
        logic [AW-1:0] ea;
        k  = wcount;
        wb = sram_we[1] ? 1 : 0;
        ea = AW'((((k % TOT) >> 3) << 2) | (k & 3));
        chk(wb == ((k >> 2) & 1), "R2", "write bank", W'(wb), W'((k >> 2) & 1));
        chk(sram_addr[wb*AW +: AW] == ea, "R2", "write addr",
            W'(sram_addr[wb*AW +: AW]), W'(ea));
        if (k < acc.size())
          chk(sram_wdata[wb*W +: W] == acc[k], "R8", "write data", sram_wdata[wb*W +: W], acc[k]);
        else
          chk(1'b0, "R5", "unexpected write", W'(k), W'(acc.size()));
        wcount++;
      end
      if ((sram_en & ~sram_we) != 2'b00) begin
        if ((sram_en & sram_we) != 2'b00)
          chk(((sram_en & ~sram_we) & (sram_en & sram_we)) == 2'b00, "R6", "read/write bank clash",
              W'(sram_en), W'(sram_we));
        if (!first_rd_seen) begin
          first_rd_seen = 1;
          chk(wcount == 5, "R6", "first read released with fifth write", W'(wcount), W'(5));
        end
      end
      if (phase2 && full) full_seen_p2 = 1;
      if (dw_valid && dw_ready) begin
        logic [W-1:0]   wv;
        logic [W/2-1:0] ev;
        if ((rdc >> 1) < acc.size()) begin
          wv = acc[rdc >> 1];
          ev = (rdc & 1) ? wv[W-1:W/2] : wv[W/2-1:0];
          chk(dw_data == ev, "R3", "dword order", W'(dw_data), W'(ev));
        end else begin
          chk(1'b0, "R3", "extra dword", W'(rdc), W'(2*acc.size()));
        end
        rdc++;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W/2-1:0] held;
    int guard;
    repeat (4) tick();
    @(negedge clk);
    chk(empty == 1'b1 && full == 1'b0, "R1", "flags in reset", W'({empty, full}), W'(2'b10));
    chk(overflow == 1'b0 && dw_valid == 1'b0, "R1", "overflow/valid in reset",
        W'({overflow, dw_valid}), W'(0));
    chk(sram_en == 2'b00, "R1", "sram idle in reset", W'(sram_en), W'(0));
    tick();
    rst = 1'b0;
    @(negedge clk);
    chk(empty && !full && !overflow && !dw_valid && sram_en == 2'b00, "R1", "state after reset",
        W'({empty, full, overflow, dw_valid, sram_en}), W'(6'b100000));

    // Phase 1: 18 back-to-back writes, bus stalled. Words 0..16 fit, word 17 dropped.
    for (int k = 0; k < 17; k++) acc.push_back(word_val(k));
    for (int k = 0; k < 18; k++) begin
      tick();
      wr_valid = 1'b1;
      wr_data  = word_val(k);
    end
    tick();
    wr_valid = 1'b0;
    tick();
    @(negedge clk);
    chk(full == 1'b1 && empty == 1'b0, "R4", "full after capacity", W'({full, empty}), W'(2'b10));
    chk(overflow == 1'b1, "R5", "overflow after drop", W'(overflow), W'(1));
    chk(wcount == 17, "R5", "dropped word not written", W'(wcount), W'(17));
    chk(dw_valid == 1'b1 && dw_data == word_val(0)[31:0], "R3", "first dword is low half",
        W'(dw_data), W'(word_val(0)[31:0]));
    held = dw_data;
    repeat (5) tick();
    @(negedge clk);
    chk(dw_valid == 1'b1 && dw_data == held, "R7", "held under back-pressure", W'(dw_data), W'(held));

    // Drain
    tick();
    dw_ready = 1'b1;
    guard = 0;
    while (rdc < 34 && guard < 2000) begin tick(); guard++; end
    repeat (3) tick();
    @(negedge clk);
    chk(rdc == 34, "R3", "even dword total phase 1", W'(rdc), W'(34));
    chk(empty == 1'b1 && full == 1'b0 && dw_valid == 1'b0, "R4", "empty after drain",
        W'({empty, full, dw_valid}), W'(3'b100));

    // Phase 2: spaced writes with a bursty bus, wrapping the pointers.
    tick();
    phase2 = 1;
    for (int k = 18; k < 38; k++) acc.push_back(word_val(k));
    fork
      begin
        for (int k = 18; k < 38; k++) begin
          wr_valid = 1'b1;
          wr_data  = word_val(k);
          tick();
          wr_valid = 1'b0;
          repeat (5) tick();
        end
      end
      begin
        for (int i = 0; i < 120; i++) begin
          dw_ready = (i % 3) != 0;
          tick();
        end
        dw_ready = 1'b1;
      end
    join
    guard = 0;
    while (rdc < 2 * 37 && guard < 3000) begin tick(); guard++; end
    repeat (3) tick();
    @(negedge clk);
    chk(rdc == 74, "R8", "all words delivered across wrap", W'(rdc), W'(74));
    chk(wcount == 37, "R8", "write count across wrap", W'(wcount), W'(37));
    chk(full_seen_p2 == 1'b0, "R4", "no full in phase 2", W'(full_seen_p2), W'(0));
    chk(empty == 1'b1, "R4", "empty at end", W'(empty), W'(1));
    chk(overflow == 1'b1, "R5", "overflow sticky", W'(overflow), W'(1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule